// File: doc/BRIEF.md
# Character glyph blitter engine

This block draws one character into video memory by itself. Video memory holds packed pixels: two 3-bit colour pixels per byte. Each colour pixel has one bit each for red, green and blue, and each bit is simply on or off, which gives eight colours. A glyph is 16 pixels wide and 8 lines tall. The processor loads the job fields (character code, X, Y, foreground colour, background colour and page) and pulses a start strobe. It then only watches a done flag. Every glyph pixel becomes either the foreground or the background colour.

The engine issues 64 byte writes over a request/grant memory port. There are 8 bytes per glyph row and 8 rows. The arbiter outside the block raises grant only in memory slots that video refresh does not need. The engine advances only when a write is granted. Between grants it holds the address and the data.

A small built-in glyph table covers a few character codes. The bench therefore needs no font file.

Top module: `glyph_blit`

## Requirements
- R1: After reset, busy_o, done_o and req_o are low.
- R2: A start_i pulse while busy_o is low captures all job fields. From the next cycle, busy_o and req_o are high and done_o is low.
- R3: The write byte holds the lower-X pixel in bits [6:4] and the higher-X pixel in bits [2:0]. Bits 7 and 3 are always zero.
- R4: A glyph bit of 1 selects fg_i and a glyph bit of 0 selects bg_i. Bit 15 of a glyph row is the leftmost pixel.
  - Code 0x01 is all ones.
  - Code 0x02 is 16'hAAAA on even rows and 16'h5555 on odd rows.
  - Code 0x03 is a box: 16'hFFFF on rows 0 and 7, and 16'h8001 on the other rows.
  - Every other code is blank (all zeros).
- R5: The byte address is {page, (y + row) mod 512, (x[9:1] + col) mod 512}. It is 21 bits wide. An odd X is rounded down to the even pixel below it.
- R6: The writes run row by row from top to bottom, and left to right within a row. There are exactly 64 granted writes per job.
- R7: The engine advances only on a cycle where req_o and gnt_i are both high. On any other cycle, addr_o and wdata_o hold their values.
- R8: done_o rises on the clock edge that takes the final granted write, and busy_o and req_o fall on that same edge. done_o then stays high until the next accepted start.
- R9: A start_i pulse while busy_o is high is ignored. The current job continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| char_i | input | 8 | Character code |
| x_i | input | 10 | Left pixel column |
| y_i | input | 9 | Top line |
| fg_i | input | 3 | Foreground colour (RGB) |
| bg_i | input | 3 | Background colour (RGB) |
| page_i | input | 3 | Video page |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Job finished; held until the next start |
| req_o | output | 1 | Write request |
| addr_o | output | 21 | Write byte address |
| wdata_o | output | 8 | Write byte |
| gnt_i | input | 1 | Write granted this cycle |

## Verification
A wrong column or row counter shows up on addr_o at the next granted write, and the packed pixel data shifts at the same time. A counter that advances without a grant shows up as an address that moves while grant is low, on the very next cycle. A wrong terminal count shows up as done_o rising too early or too late compared with the 64th grant. A wrong job capture shows up on the first write's address or colour, or when a start during a job is wrongly accepted and redirects the writes that follow.

// File: rtl/glyph_blit_pkg.sv
package glyph_blit_pkg;
  localparam int unsigned PIX_W    = 3;
  localparam int unsigned GLYPH_W  = 16;
  localparam int unsigned GLYPH_H  = 8;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned X_W      = 10;
  localparam int unsigned Y_W      = 9;
  localparam int unsigned PAGE_W   = 3;
  localparam int unsigned XB_W     = X_W - 1;
  localparam int unsigned ADDR_W   = PAGE_W + Y_W + XB_W;
  localparam int unsigned ROW_BYTES = GLYPH_W / 2;
  localparam int unsigned COL_W    = $clog2(ROW_BYTES);
  localparam int unsigned ROW_W    = $clog2(GLYPH_H);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [PAGE_W-1:0] page;
    logic [Y_W-1:0]    y;
    logic [XB_W-1:0]   xb;
    logic [PIX_W-1:0]  fg;
    logic [PIX_W-1:0]  bg;
  } job_t;
endpackage

// File: rtl/glyph_rom.sv
module glyph_rom
  import glyph_blit_pkg::*;
(
  input  logic [CODE_W-1:0]  code_i,
  input  logic [ROW_W-1:0]   row_i,
  output logic [GLYPH_W-1:0] bits_o
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(GLYPH_H - 1);

  always_comb begin
    unique case (code_i)
      8'h01:   bits_o = '1;
      8'h02:   bits_o = row_i[0] ? 16'h5555 : 16'hAAAA;
      8'h03:   bits_o = (row_i == '0 || row_i == LAST_ROW) ? 16'hFFFF : 16'h8001;
      default: bits_o = '0;
    endcase
  end
endmodule

// File: rtl/glyph_pack.sv
module glyph_pack
  import glyph_blit_pkg::*;
(
  input  logic [GLYPH_W-1:0] bits_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [PIX_W-1:0]   fg_i,
  input  logic [PIX_W-1:0]   bg_i,
  output logic [7:0]         byte_o
);
  logic [GLYPH_W-1:0] shifted;
  logic [PIX_W-1:0]   pix [2];

  assign shifted = bits_i << {col_i, 1'b0};

  // pixel 0 = lower X, taken from the MSB end
  for (genvar p = 0; p < 2; p++) begin : g_pix
    assign pix[p] = shifted[GLYPH_W-1-p] ? fg_i : bg_i;
  end

  assign byte_o = {1'b0, pix[0], 1'b0, pix[1]};
endmodule

// File: rtl/glyph_blit_ctrl.sv
module glyph_blit_ctrl
  import glyph_blit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  job_t              job_i,
  input  logic              gnt_i,
  output job_t              job_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(ROW_BYTES - 1);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(GLYPH_H - 1);

  state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      row_o   <= '0;
      col_o   <= '0;
      job_o   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        job_o   <= job_i;
        state_q <= ST_RUN;
        done_o  <= 1'b0;
        row_o   <= '0;
        col_o   <= '0;
      end
    end else if (gnt_i) begin
      if (col_o == LAST_COL) begin
        col_o <= '0;
        if (row_o == LAST_ROW) begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end else begin
          row_o <= row_o + 1'b1;
        end
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end

  assign busy_o = (state_q == ST_RUN);
endmodule

// File: rtl/glyph_blit.sv
module glyph_blit
  import glyph_blit_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CODE_W-1:0]   char_i,
  input  logic [X_W-1:0]      x_i,
  input  logic [Y_W-1:0]      y_i,
  input  logic [PIX_W-1:0]    fg_i,
  input  logic [PIX_W-1:0]    bg_i,
  input  logic [PAGE_W-1:0]   page_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                req_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [7:0]          wdata_o,
  input  logic                gnt_i
);
  job_t               job_in, job_q;
  logic [ROW_W-1:0]   row;
  logic [COL_W-1:0]   col;
  logic [GLYPH_W-1:0] bits;
  logic [Y_W-1:0]     line;
  logic [XB_W-1:0]    xbyte;

  assign job_in = '{code: char_i, page: page_i, y: y_i, xb: x_i[X_W-1:1],
                    fg: fg_i, bg: bg_i};

  glyph_blit_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .job_i  (job_in),
    .gnt_i,
    .job_o  (job_q),
    .row_o  (row),
    .col_o  (col),
    .busy_o,
    .done_o
  );

  glyph_rom u_rom (.code_i(job_q.code), .row_i(row), .bits_o(bits));

  glyph_pack u_pack (
    .bits_i(bits), .col_i(col), .fg_i(job_q.fg), .bg_i(job_q.bg), .byte_o(wdata_o)
  );

  // coordinates wrap modulo the line and stride sizes
  assign line   = job_q.y + Y_W'(row);
  assign xbyte  = job_q.xb + XB_W'(col);
  assign addr_o = {job_q.page, line, xbyte};
  assign req_o  = busy_o;
endmodule

// File: rtl/glyph_blit_chk.sv
module glyph_blit_chk
  import glyph_blit_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              req_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [7:0]        wdata_o,
  input logic              gnt_i
);
  a_r3_pad_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (wdata_o[7] == 1'b0 && wdata_o[3] == 1'b0));

  a_r7_hold_without_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !gnt_i) |=> ($stable(addr_o) && $stable(wdata_o) && req_o));

  a_r8_done_on_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_done_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r8_done_excl_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  a_r9_start_ignored_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !gnt_i) |=> (busy_o && $stable(addr_o)));
endmodule

bind glyph_blit glyph_blit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .req_o(req_o), .addr_o(addr_o), .wdata_o(wdata_o), .gnt_i(gnt_i)
);

// File: tb/glyph_blit_bench.sv
`timescale 1ns/1ps
module glyph_blit_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, gnt_i = 1'b0;
  logic [7:0]  char_i = '0;
  logic [9:0]  x_i = '0;
  logic [8:0]  y_i = '0;
  logic [2:0]  fg_i = '0, bg_i = '0, page_i = '0;
  logic        busy_o, done_o, req_o;
  logic [20:0] addr_o;
  logic [7:0]  wdata_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  glyph_blit u_glyph_blit (.*);

  function automatic logic [15:0] ref_row(logic [7:0] c, int r);
    case (c)
      8'h01:   return 16'hFFFF;
      8'h02:   return (r % 2) ? 16'h5555 : 16'hAAAA;
      8'h03:   return (r == 0 || r == 7) ? 16'hFFFF : 16'h8001;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // stall: 0 none, 1 grant two cycles in three; intr: inject start at write 10
  task automatic run_glyph(logic [7:0] c, logic [9:0] x, logic [8:0] y,
                           logic [2:0] fg, logic [2:0] bg, logic [2:0] pg,
                           int stall, bit intr);
    int k = 0, cyc = 0;
    @(negedge clk_i);
    char_i = c; x_i = x; y_i = y; fg_i = fg; bg_i = bg; page_i = pg; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 busy", busy_o, 1); chk("R2 req", req_o, 1); chk("R2 done", done_o, 0);
    while (k < 64) begin
      int r = k / 8, col = k % 8;
      logic [15:0] gb = ref_row(c, r);
      logic [2:0] p0 = gb[15 - 2*col] ? fg : bg;
      logic [2:0] p1 = gb[14 - 2*col] ? fg : bg;
      logic [20:0] ea = {pg, 9'(y + 9'(r)), 9'(x[9:1] + 9'(col))};
      bit g = (stall == 0) || (cyc % 3 != 0);
      chk("R5 R6 R7 addr", addr_o, ea);
      chk("R3 R4 data", wdata_o, {1'b0, p0, 1'b0, p1});
      chk("R7 req", req_o, 1);
      gnt_i = g;
      if (intr && k == 10) begin
        char_i = 8'h01; x_i = 10'd100; y_i = 9'd3; page_i = ~pg; start_i = 1'b1;
      end else start_i = 1'b0;
      @(negedge clk_i);
      if (g) k++;
      cyc++;
    end
    gnt_i = 1'b0; start_i = 1'b0;
    chk("R8 done", done_o, 1); chk("R8 busy", busy_o, 0); chk("R8 req", req_o, 0);
  endtask

  task automatic test_reset();
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0); chk("R1 req", req_o, 0);
  endtask

  task automatic test_done_hold();
    repeat (5) @(negedge clk_i);
    chk("R8 done held", done_o, 1); chk("R8 idle req", req_o, 0);
  endtask

  initial begin
    #1;
    test_reset();
    #10 rst_ni = 1'b1;
    run_glyph(8'h00, 10'd0, 9'd0, 3'd7, 3'd1, 3'd0, 0, 0);     // blank, bg only
    run_glyph(8'h01, 10'd5, 9'd20, 3'd4, 3'd2, 3'd1, 0, 0);    // R5 odd X
    run_glyph(8'h02, 10'd64, 9'd100, 3'd6, 3'd1, 3'd2, 1, 0);  // R7 stalls
    test_done_hold();
    run_glyph(8'h03, 10'd1020, 9'd508, 3'd3, 3'd5, 3'd7, 1, 0); // R5 wrap
    run_glyph(8'h41, 10'd300, 9'd50, 3'd2, 3'd6, 3'd4, 0, 0);  // R4 unknown code
    run_glyph(8'h03, 10'd12, 9'd7, 3'd1, 3'd0, 3'd5, 1, 1);    // R9 start while busy
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule